// File: doc/BRIEF.md
# 36-bit Host Word Lane Packer

This block sits in a DMA path between a peripheral bus that moves 8-bit bytes and 16-bit or 18-bit words and a host memory built from 36-bit words. Every host word holds four bus bytes split into two 18-bit halves. Each half keeps its 16 data bits in the low part and two extra bits above them. For a read, the block takes the stored host word and a bus byte offset and returns the selected byte, 16-bit word or 18-bit word. For a write, it builds the new host word and a bit mask. It also reports whether the old word must be read first or whether the store can skip the read-modify-write.

A companion segment calculator takes the starting offset and a byte count and splits the transfer into three parts: an unaligned head, whole host words, and a short tail. Every result is registered, so outputs appear one clock after the request.

Top module: `lane_pack`

## Requirements
- R1: While rst_ni is low, every output is zero.
- R2: Byte read (mode 0) returns the byte zero-extended to 18 bits. Offset 0 comes from host bits 25:18, offset 1 from 33:26, offset 2 from 7:0 and offset 3 from 15:8.
- R3: A 16-bit read (mode 1) returns host bits 33:18 when ofs_i[1] is 0 and bits 15:0 when it is 1. An 18-bit read (mode 2) returns 35:18 or 17:0 in the same way. Extra bits are dropped in mode 1.
- R4: In a read-modify-write byte write, the mask covers only the target byte lane. Offsets 1 and 3 also write zero into the two extra bits of that half; offsets 0 and 2 keep them. Every bit outside the mask equals host_rd_i.
- R5: A 16-bit write replaces the whole addressed half, with its two extra bits cleared. An 18-bit write stores all 18 data bits into that half.
- R6: A write at offset 0 with rrev_i low skips the read-modify-write. rmw_o is 0, the mask is all ones, and every host bit outside the written lane is zero.
- R7: Any other write, including any write with rrev_i high, sets rmw_o.
- R8: Modes 1 and 2 with odd ofs_i or odd cnt_i raise align_err_o. In that case the mask is zero, rmw_o is 0, rdata_o is 0 and host_wr_o equals host_rd_i.
- R9: The head length is the smaller of cnt_i and (4 - ofs_i) mod 4. Of the bytes that remain, body_o counts whole 4-byte words and tail_o holds the leftover 0 to 3 bytes.
- R10: vld_o follows req_i one cycle later, and all results use the same one-cycle latency.
- R11: A read (wr_i low) gives a zero mask, rmw_o low, and host_wr_o equal to host_rd_i. Mode code 3 acts as a byte access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid |
| wr_i | input | 1 | 1 = write, 0 = read |
| mode_i | input | 2 | 0 byte, 1 16-bit word, 2 18-bit word |
| ofs_i | input | 2 | Bus byte offset within the host word |
| rrev_i | input | 1 | Force read-modify-write |
| cnt_i | input | CNT_W | Transfer byte count |
| host_rd_i | input | 36 | Current host word |
| wdata_i | input | 18 | Write data, right-aligned |
| vld_o | output | 1 | Results valid |
| rdata_o | output | 18 | Extracted read data |
| host_wr_o | output | 36 | New host word |
| wmask_o | output | 36 | Bits to store |
| rmw_o | output | 1 | Old word must be read first |
| align_err_o | output | 1 | Alignment error |
| head_o | output | 2 | Head byte count |
| body_o | output | CNT_W-2 | Whole host words |
| tail_o | output | 2 | Tail byte count |

## Verification
A wrong lane select or a wrong half select shows up on rdata_o, host_wr_o and wmask_o one clock after the request. Sweeping every offset with distinct data bytes exposes any swapped byte or half. A wrong extra-bit rule shows up only on writes whose old word holds ones in bits 35:34 or 17:16, so the sweep includes an all-ones old word. A wrong bypass or alignment decision changes rmw_o or align_err_o in that same cycle. A wrong segment split shows on head_o, body_o and tail_o for counts near word boundaries.

// File: rtl/lane_pack_pkg.sv
package lane_pack_pkg;
  typedef enum logic [1:0] {
    XFER_BYTE = 2'd0,
    XFER_W16  = 2'd1,
    XFER_W18  = 2'd2,
    XFER_RSVD = 2'd3
  } xfer_e;
endpackage

// File: rtl/lane_pack_rd.sv
module lane_pack_rd
  import lane_pack_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int XB_W   = 2,
  localparam int HALF_W = 2*BYTE_W + XB_W,
  localparam int HOST_W = 2*HALF_W
) (
  input  logic [HOST_W-1:0] word_i,
  input  logic [1:0]        ofs_i,
  input  xfer_e             mode_i,
  output logic [HALF_W-1:0] data_o
);
  logic [HALF_W-1:0] half;

  // offset bit 1 selects the low half
  assign half = ofs_i[1] ? word_i[HALF_W-1:0] : word_i[HOST_W-1:HALF_W];

  always_comb begin
    unique case (mode_i)
      XFER_W16: data_o = HALF_W'(half[2*BYTE_W-1:0]);
      XFER_W18: data_o = half;
      default:  data_o = ofs_i[0] ? HALF_W'(half[2*BYTE_W-1:BYTE_W])
                                  : HALF_W'(half[BYTE_W-1:0]);
    endcase
  end
endmodule

// File: rtl/lane_pack_wr.sv
module lane_pack_wr
  import lane_pack_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int XB_W   = 2,
  localparam int HALF_W = 2*BYTE_W + XB_W,
  localparam int HOST_W = 2*HALF_W
) (
  input  logic [HOST_W-1:0] old_i,
  input  logic [HALF_W-1:0] data_i,
  input  logic [1:0]        ofs_i,
  input  xfer_e             mode_i,
  input  logic              bypass_i,
  output logic [HOST_W-1:0] new_o,
  output logic [HOST_W-1:0] mask_o
);
  logic [HALF_W-1:0] hval, hmsk;
  logic [HOST_W-1:0] lane, lmsk;

  always_comb begin
    unique case (mode_i)
      XFER_W16: begin
        hval = {{XB_W{1'b0}}, data_i[2*BYTE_W-1:0]};
        hmsk = '1;
      end
      XFER_W18: begin
        hval = data_i;
        hmsk = '1;
      end
      default: begin
        if (ofs_i[0]) begin
          // high byte of a half also zeroes the extra bits
          hval = {{XB_W{1'b0}}, data_i[BYTE_W-1:0], {BYTE_W{1'b0}}};
          hmsk = {{XB_W{1'b1}}, {BYTE_W{1'b1}}, {BYTE_W{1'b0}}};
        end else begin
          hval = {{(XB_W+BYTE_W){1'b0}}, data_i[BYTE_W-1:0]};
          hmsk = {{(XB_W+BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
        end
      end
    endcase
  end

  assign lane = ofs_i[1] ? {{HALF_W{1'b0}}, hval} : {hval, {HALF_W{1'b0}}};
  assign lmsk = ofs_i[1] ? {{HALF_W{1'b0}}, hmsk} : {hmsk, {HALF_W{1'b0}}};

  assign new_o  = bypass_i ? lane : ((old_i & ~lmsk) | lane);
  assign mask_o = bypass_i ? '1 : lmsk;
endmodule

// File: rtl/lane_pack_seg.sv
module lane_pack_seg #(
  parameter int CNT_W = 12
) (
  input  logic [1:0]       ofs_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [1:0]       head_o,
  output logic [CNT_W-3:0] body_o,
  output logic [1:0]       tail_o
);
  logic [1:0]       lead;
  logic [CNT_W-1:0] rem;

  assign lead   = 2'(3'd4 - {1'b0, ofs_i});
  assign head_o = (cnt_i < CNT_W'(lead)) ? cnt_i[1:0] : lead;
  assign rem    = cnt_i - CNT_W'(head_o);
  assign body_o = rem[CNT_W-1:2];
  assign tail_o = rem[1:0];
endmodule

// File: rtl/lane_pack.sv
module lane_pack
  import lane_pack_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int XB_W   = 2,
  parameter int CNT_W  = 12,
  localparam int HALF_W = 2*BYTE_W + XB_W,
  localparam int HOST_W = 2*HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        ofs_i,
  input  logic              rrev_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [HOST_W-1:0] host_rd_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic              vld_o,
  output logic [HALF_W-1:0] rdata_o,
  output logic [HOST_W-1:0] host_wr_o,
  output logic [HOST_W-1:0] wmask_o,
  output logic              rmw_o,
  output logic              align_err_o,
  output logic [1:0]        head_o,
  output logic [CNT_W-3:0]  body_o,
  output logic [1:0]        tail_o
);
  xfer_e             mode;
  logic              wide, err, bypass, do_wr;
  logic [HALF_W-1:0] rd_data;
  logic [HOST_W-1:0] wr_word, wr_mask;
  logic [1:0]        head_c, tail_c;
  logic [CNT_W-3:0]  body_c;

  assign mode   = xfer_e'(mode_i);
  assign wide   = (mode == XFER_W16) || (mode == XFER_W18);
  assign err    = wide && (ofs_i[0] || cnt_i[0]);
  assign bypass = (ofs_i == 2'd0) && !rrev_i;
  assign do_wr  = wr_i && !err;

  lane_pack_rd #(.BYTE_W(BYTE_W), .XB_W(XB_W)) u_rd (
    .word_i (host_rd_i),
    .ofs_i  (ofs_i),
    .mode_i (mode),
    .data_o (rd_data)
  );

  lane_pack_wr #(.BYTE_W(BYTE_W), .XB_W(XB_W)) u_wr (
    .old_i    (host_rd_i),
    .data_i   (wdata_i),
    .ofs_i    (ofs_i),
    .mode_i   (mode),
    .bypass_i (bypass),
    .new_o    (wr_word),
    .mask_o   (wr_mask)
  );

  lane_pack_seg #(.CNT_W(CNT_W)) u_seg (
    .ofs_i  (ofs_i),
    .cnt_i  (cnt_i),
    .head_o (head_c),
    .body_o (body_c),
    .tail_o (tail_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o       <= 1'b0;
      rdata_o     <= '0;
      host_wr_o   <= '0;
      wmask_o     <= '0;
      rmw_o       <= 1'b0;
      align_err_o <= 1'b0;
      head_o      <= '0;
      body_o      <= '0;
      tail_o      <= '0;
    end else begin
      vld_o       <= req_i;
      rdata_o     <= (wr_i || err) ? '0 : rd_data;
      host_wr_o   <= do_wr ? wr_word : host_rd_i;
      wmask_o     <= do_wr ? wr_mask : '0;
      rmw_o       <= do_wr && !bypass;
      align_err_o <= err;
      head_o      <= head_c;
      body_o      <= body_c;
      tail_o      <= tail_c;
    end
  end
endmodule

// File: rtl/lane_pack_chk.sv
module lane_pack_chk #(
  parameter int CNT_W  = 12,
  parameter int HOST_W = 36
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              wr_i,
  input logic [1:0]        mode_i,
  input logic [1:0]        ofs_i,
  input logic              rrev_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [HOST_W-1:0] host_rd_i,
  input logic              vld_o,
  input logic [HOST_W-1:0] host_wr_o,
  input logic [HOST_W-1:0] wmask_o,
  input logic              rmw_o,
  input logic              align_err_o,
  input logic [1:0]        head_o,
  input logic [CNT_W-3:0]  body_o,
  input logic [1:0]        tail_o
);
  // R10
  vld_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o == $past(req_i));

  // R11
  rd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> (wmask_o == '0 && !rmw_o && host_wr_o == $past(host_rd_i)));

  // R8
  align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && mode_i == 2'd1 && ofs_i[0]) |=> (align_err_o && wmask_o == '0 && !rmw_o));

  // R7
  rrev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rrev_i && mode_i == 2'd0) |=> rmw_o);

  // R6
  bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rrev_i && ofs_i == 2'd0 && !cnt_i[0]) |=> (!rmw_o && (&wmask_o)));

  // R4
  keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rmw_o) |-> ((host_wr_o ^ $past(host_rd_i)) & ~wmask_o) == '0);

  // R9
  seg_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> ((CNT_W+1)'(head_o) + (CNT_W+1)'({body_o, 2'b00}) + (CNT_W+1)'(tail_o))
              == (CNT_W+1)'($past(cnt_i)));
endmodule

bind lane_pack lane_pack_chk #(.CNT_W(CNT_W), .HOST_W(HOST_W)) i_lane_pack_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .wr_i        (wr_i),
  .mode_i      (mode_i),
  .ofs_i       (ofs_i),
  .rrev_i      (rrev_i),
  .cnt_i       (cnt_i),
  .host_rd_i   (host_rd_i),
  .vld_o       (vld_o),
  .host_wr_o   (host_wr_o),
  .wmask_o     (wmask_o),
  .rmw_o       (rmw_o),
  .align_err_o (align_err_o),
  .head_o      (head_o),
  .body_o      (body_o),
  .tail_o      (tail_o)
);

// File: tb/test_lane_pack.sv
`timescale 1ns/1ps
module test_lane_pack;
  localparam int CNT_W = 12;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0, wr_i = 1'b0, rrev_i = 1'b0;
  logic [1:0]        mode_i = '0, ofs_i = '0;
  logic [CNT_W-1:0]  cnt_i = '0;
  logic [35:0]       host_rd_i = '0;
  logic [17:0]       wdata_i = '0;
  logic              vld_o, rmw_o, align_err_o;
  logic [17:0]       rdata_o;
  logic [35:0]       host_wr_o, wmask_o;
  logic [1:0]        head_o, tail_o;
  logic [CNT_W-3:0]  body_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lane_pack #(.CNT_W(CNT_W)) i_lane_pack (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .wr_i(wr_i), .mode_i(mode_i),
    .ofs_i(ofs_i), .rrev_i(rrev_i), .cnt_i(cnt_i), .host_rd_i(host_rd_i),
    .wdata_i(wdata_i), .vld_o(vld_o), .rdata_o(rdata_o), .host_wr_o(host_wr_o),
    .wmask_o(wmask_o), .rmw_o(rmw_o), .align_err_o(align_err_o),
    .head_o(head_o), .body_o(body_o), .tail_o(tail_o)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input bit wr, input int mode, input int ofs, input bit rrev,
                       input int cnt, input logic [35:0] old, input logic [17:0] d);
    @(negedge clk);
    req_i = 1'b1; wr_i = wr; mode_i = 2'(mode); ofs_i = 2'(ofs); rrev_i = rrev;
    cnt_i = CNT_W'(cnt); host_rd_i = old; wdata_i = d;
    @(negedge clk);
  endtask

  task automatic one_case(input bit wr, input int mode, input int ofs, input bit rrev,
                          input int cnt, input logic [35:0] old, input logic [17:0] d);
    logic [35:0] lane, lm, e_wr, e_msk;
    logic [17:0] e_rd;
    bit e_err, e_rmw;
    int base, pos;
    string tg;
    base  = (ofs >= 2) ? 0 : 18;
    pos   = base + ((ofs % 2) ? 8 : 0);
    e_err = (mode != 0) && (((ofs % 2) != 0) || ((cnt % 2) != 0));
    lane = '0; lm = '0; e_rd = '0;
    if (mode == 0) begin
      for (int i = 0; i < 8; i++) begin lane[pos+i] = d[i]; lm[pos+i] = 1'b1; e_rd[i] = old[pos+i]; end
      if (ofs % 2) begin lm[base+16] = 1'b1; lm[base+17] = 1'b1; end
    end else begin
      for (int i = 0; i < 18; i++) begin
        lm[base+i] = 1'b1;
        if (i < 16 || mode == 2) begin lane[base+i] = d[i]; e_rd[i] = old[base+i]; end
      end
    end
    if (!wr || e_err) begin
      e_wr = old; e_msk = '0; e_rmw = 0;
      if (e_err) e_rd = '0;
      if (wr) e_rd = '0;
    end else if (ofs == 0 && !rrev) begin
      e_wr = lane; e_msk = '1; e_rmw = 0; e_rd = '0;
    end else begin
      e_wr = (old & ~lm) | lane; e_msk = lm; e_rmw = 1; e_rd = '0;
    end
    drive(wr, mode, ofs, rrev, cnt, old, d);
    if (e_err) tg = "R8";
    else if (!wr) tg = (mode == 0) ? "R2" : "R3";
    else if (ofs == 0 && !rrev) tg = "R6";
    else tg = (mode == 0) ? "R4" : "R5";
    check({tg, " rdata"}, 64'(rdata_o), 64'(e_rd));
    check({tg, " host_wr"}, 64'(host_wr_o), 64'(e_wr));
    check({tg, " wmask"}, 64'(wmask_o), 64'(e_msk));
    check((wr && rrev && !e_err) ? "R7 rmw" : {tg, " rmw"}, 64'(rmw_o), 64'(e_rmw));
    check("R8 align_err", 64'(align_err_o), 64'(e_err));
    check("R10 vld", 64'(vld_o), 64'd1);
    if (!wr) check("R11 rd mask", 64'(wmask_o), 64'd0);
  endtask

  logic [35:0] olds [4];
  logic [17:0] dats [4];

  initial begin
    olds[0] = 36'hFFFFFFFFF; olds[1] = 36'h000000000;
    olds[2] = 36'h9C3E1F0B7; olds[3] = 36'h5A5A5A5A5;
    dats[0] = 18'h0A5C3; dats[1] = 18'h3FFFF; dats[2] = 18'h2F00D; dats[3] = 18'h1B7E4;
    #3;
    // R1
    check("R1 vld", 64'(vld_o), 0);
    check("R1 host_wr", 64'(host_wr_o), 0);
    check("R1 wmask", 64'(wmask_o), 0);
    check("R1 seg", 64'({head_o, body_o, tail_o}), 0);
    #20 rst_ni = 1'b1;
    @(negedge clk);
    check("R10 idle vld", 64'(vld_o), 0);
    for (int p = 0; p < 4; p++)
      for (int m = 0; m < 3; m++)
        for (int w = 0; w < 2; w++)
          for (int o = 0; o < 4; o++)
            for (int r = 0; r < 2; r++)
              one_case(w[0], m, o, r[0], 8, olds[p], dats[p]);
    // odd count on wide modes and on byte mode
    one_case(1, 1, 0, 0, 5, olds[2], dats[2]);
    one_case(0, 2, 2, 0, 3, olds[3], dats[3]);
    one_case(1, 0, 0, 0, 3, olds[2], dats[2]);
    // mode code 3 acts as byte (R11)
    drive(0, 3, 1, 0, 4, olds[2], dats[2]);
    check("R11 mode3 rdata", 64'(rdata_o), 64'(olds[2][33:26]));
    // segment split sweep (R9)
    for (int o = 0; o < 4; o++)
      for (int c = 0; c < 40; c++) begin
        int ld, h, rm;
        ld = (4 - o) % 4;
        h  = (c < ld) ? c : ld;
        rm = c - h;
        drive(0, 0, o, 0, c, olds[1], dats[1]);
        check("R9 head", 64'(head_o), 64'(h));
        check("R9 body", 64'(body_o), 64'(rm / 4));
        check("R9 tail", 64'(tail_o), 64'(rm % 4));
      end
    @(negedge clk);
    req_i = 1'b0;
    @(negedge clk);
    check("R10 drop vld", 64'(vld_o), 0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule